// File: doc/BRIEF.md
# NIC interrupt status summarizer

This block keeps the interrupt status word and the interrupt enable word of an Ethernet controller. The transmit and receive engines, the timer and the link logic report events as single-cycle pulses on a 32-bit event vector. Each pulse sets a sticky status bit. The host clears status bits by writing ones, and writes the enable word directly. Two summary bits sort the pending, enabled sources into a normal class and an abnormal class. A level interrupt output is raised when an enabled summary is set.

Event bit positions: transmit done 0, transmit stopped 1, transmit buffer unavailable 2, transmit jabber 3, link pass 4, underflow 5, receive done 6, receive buffer unavailable 7, receive stopped 8, receive watchdog 9, early transmit 10, timer expired 11, link fail 12, fatal bus error 13, early receive 14, link change / general-purpose input 27. Bit 15 is the abnormal summary and bit 16 is the normal summary. The normal class is bits {0,2,6,11,14}. The abnormal class is bits {1,3,4,5,7,8,9,10,12,13,27}. All other status bits are process-state fields that this block does not manage. They keep their reset value.

Top module: `nic_irq_summary`

## Requirements
- R1: After reset the status word reads 0xF0000000, the enable word reads 0xF3FE0000 and `irq_o` is low.
- R2: An event pulse at an event position (bits 0 to 14 and 27) sets that status bit on the next clock edge, and the bit stays set until it is cleared. A pulse at any other position has no effect on the status word.
- R3: A write to the status word (`reg_sel_i`=0) clears each event bit and summary bit whose data bit is 1. Bits written as 0 keep their value. Bits 17 to 26 and 28 to 31 keep their reset value under every write.
- R4: If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit is set after that edge.
- R5: Status bit 16 is 1 exactly when some bit in {0,2,6,11,14} is set in both the status word and the enable word.
- R6: Status bit 15 is 1 exactly when some bit in {1,3,4,5,7,8,9,10,12,13,27} is set in both the status word and the enable word.
- R7: The summaries are recomputed on every change of status or enable. Writing a 1 to a summary bit does not clear it while a matching enabled source is still pending. Clearing the last source, or disabling it, clears the summary on the same edge.
- R8: `irq_o` is high exactly when (status bit 16 and enable bit 16) or (status bit 15 and enable bit 15) is true. It follows a register write on the same edge, with no further delay.
- R9: A write to the enable word (`reg_sel_i`=1) stores all 32 data bits. The read port returns the status word when `reg_sel_i`=0 and the enable word when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Single-cycle event pulses at status bit positions |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable (read and write) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong sticky bit or a missed clear appears on the status readback on the first edge after the event or write. A stale summary bit appears there on the same edge, and it also drives `irq_o` high or low wrongly in that cycle. Enable-word corruption is visible at once through readback and through the summary bits, which are recomputed from it. Because of this, the bench compares both registers and `irq_o` against a reference model after every edge, so a divergence is caught within one cycle.

// File: rtl/nic_irq_summary.sv
module nic_irq_summary #(
  parameter logic [31:0] STATUS_RST = 32'hF000_0000,
  parameter logic [31:0] ENABLE_RST = 32'hF3FE_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] evt_i,
  input  logic        reg_wr_i,
  input  logic        reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam logic [31:0] NORM_MASK = 32'h0000_4845;
  localparam logic [31:0] ABN_MASK  = 32'h0800_37BA;
  localparam logic [31:0] EVT_MASK  = NORM_MASK | ABN_MASK;
  localparam int          AIS_BIT   = 15;
  localparam int          NIS_BIT   = 16;
  localparam logic [31:0] FIXED     = STATUS_RST & ~EVT_MASK & ~(32'h3 << AIS_BIT);

  logic [31:0] ev_q, en_q, ev_d, en_d, clr;
  logic        nis_q, ais_q;

  assign clr  = (reg_wr_i && !reg_sel_i) ? reg_wdata_i : 32'h0;
  assign ev_d = ((ev_q & ~clr) | evt_i) & EVT_MASK;
  assign en_d = (reg_wr_i && reg_sel_i) ? reg_wdata_i : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= STATUS_RST & EVT_MASK;
      en_q  <= ENABLE_RST;
      nis_q <= 1'b0;
      ais_q <= 1'b0;
    end else begin
      ev_q  <= ev_d;
      en_q  <= en_d;
      nis_q <= |(ev_d & en_d & NORM_MASK);
      ais_q <= |(ev_d & en_d & ABN_MASK);
    end
  end

  logic [31:0] status;
  assign status = FIXED | ev_q | ({31'h0, nis_q} << NIS_BIT) | ({31'h0, ais_q} << AIS_BIT);

  assign reg_rdata_o = reg_sel_i ? en_q : status;
  assign irq_o       = (nis_q & en_q[NIS_BIT]) | (ais_q & en_q[AIS_BIT]);
endmodule

module nic_irq_summary_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_i,
  input logic        reg_wr_i,
  input logic        reg_sel_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] ev_q,
  input logic [31:0] en_q,
  input logic        nis_q,
  input logic        ais_q,
  input logic        irq_o
);
  localparam logic [31:0] NORM = 32'h0000_4845;
  localparam logic [31:0] ABN  = 32'h0800_37BA;
  localparam logic [31:0] EVT  = NORM | ABN;

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & EVT)) |=> ((ev_q & $past(evt_i & EVT)) == $past(evt_i & EVT))); // R2
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !reg_sel_i) |=> ((ev_q & $past(ev_q & ~reg_wdata_i)) == $past(ev_q & ~reg_wdata_i))); // R3
  AST_ONLY_EVT_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q & ~EVT) == 32'h0); // R2
  AST_NIS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    nis_q == (|(ev_q & en_q & NORM))); // R5
  AST_AIS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ais_q == (|(ev_q & en_q & ABN))); // R6
  AST_IRQ_NEEDS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (nis_q || ais_q)); // R8
  AST_EN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_sel_i) |=> (en_q == $past(reg_wdata_i))); // R9
endmodule

bind nic_irq_summary nic_irq_summary_chk chk_i (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
  .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .ev_q(ev_q),
  .en_q(en_q), .nis_q(nis_q), .ais_q(ais_q), .irq_o(irq_o)
);

// File: tb/nic_irq_summary_tb.sv
`timescale 1ns/1ps
module nic_irq_summary_tb_top;
  localparam logic [31:0] NORM = 32'h0000_4845;
  localparam logic [31:0] ABN  = 32'h0800_37BA;
  localparam logic [31:0] EVT  = NORM | ABN;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] evt = '0, wdata = '0, rdata;
  logic wr = 1'b0, sel = 1'b0, irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] ev_m, en_m;

  always #4 clk = ~clk;

  nic_irq_summary dut_i (.clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

  function automatic logic [31:0] exp_status(logic [31:0] ev, logic [31:0] en);
    logic n = |(ev & en & NORM);
    logic a = |(ev & en & ABN);
    return 32'hF000_0000 | ev | {15'h0, n, a, 15'h0};
  endfunction

  function automatic logic exp_irq(logic [31:0] ev, logic [31:0] en);
    logic [31:0] s = exp_status(ev, en);
    return (s[16] & en[16]) | (s[15] & en[15]);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    sel = 1'b0; #1;
    check({tag, " status"}, rdata, exp_status(ev_m, en_m));
    check({tag, " irq R8"}, {31'h0, irq}, {31'h0, exp_irq(ev_m, en_m)});
    sel = 1'b1; #1;
    check({tag, " enable R9"}, rdata, en_m);
  endtask

  task automatic step(logic [31:0] e, logic w, logic s, logic [31:0] d, string tag);
    @(negedge clk);
    evt = e; wr = w; sel = s; wdata = d;
    @(posedge clk);
    ev_m = ((ev_m & ~((w && !s) ? d : 32'h0)) | e) & EVT;
    if (w && s) en_m = d;
    @(negedge clk);
    evt = '0; wr = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    void'($urandom(seed));
    ev_m = '0; en_m = 32'hF3FE_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    step(32'h1, 1'b0, 1'b0, 0, "R2 evt with enables off");
    step(0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R9 enable all, R5 recompute");
    step(0, 1'b1, 1'b0, 32'h0, "R3 write zero keeps");
    step(0, 1'b1, 1'b0, 32'h0001_0000, "R7 clear NIS with source pending");
    step(0, 1'b1, 1'b0, 32'h0000_0001, "R3 R7 clear source");
    step(32'h0800_0000, 1'b0, 1'b0, 0, "R6 link change");
    step(32'h0800_0000, 1'b1, 1'b0, 32'h0800_0000, "R4 event beats clear");
    step(32'h0010_0000, 1'b0, 1'b0, 0, "R2 non-event bit ignored");
    step(0, 1'b1, 1'b1, 32'hFFFF_7FFF, "R8 abnormal masked at pin");
    step(0, 1'b1, 1'b1, 32'hF7FF_FFFF, "R7 source disabled");
    step(0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R3 clear all, fixed fields");
    step(32'h0000_4000, 1'b1, 1'b1, 32'h0001_4000, "R5 early receive");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] e = $urandom & $urandom & $urandom;
      logic w = ($urandom % 3) == 0;
      logic s = $urandom % 2;
      logic [31:0] d = $urandom;
      step(e, w, s, d, "R2 R3 R5 R6 R8 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule